// File: doc/BRIEF.md
# Shared-Bus Memory and Port Responder

This block sits on the target side of a simple system bus that carries memory cycles and port cycles over the same address, data and control wires. A single master raises a read strobe or a write strobe. A separate I/O-select line marks the cycle as port space; when that line is low, the cycle is in memory space. The responder decodes the cycle to a small word memory or to one of three port registers. It completes the cycle with a one-cycle READY pulse, and it takes no further command until both strobes have gone low again. A double-width item moves as two beats on back-to-back cycles, low half first.

Port space holds three registers. The first is a status register whose bit 1 shows that a one-byte input buffer is full. The second is a data register that returns that byte and empties the buffer. The third is a control register that stores byte writes zero-extended to the bus width. The device side fills the buffer through a push input. A cycle that nothing claims gets no READY and changes no state. After a fixed wait, a timeout pulse releases the master.

Top module: `bus_responder`

## Requirements
- R1: After reset, bus_ready, bus_timeout and bus_rdata are 0, all memory words are 0, the input buffer is empty and the control register is 0.
- R2: A memory cycle (bus_io low) at an address below MEM_DEPTH completes with bus_ready high in the cycle after the first clock edge that sees the strobe. A write stores the full bus_wdata word. A read returns the stored word on bus_rdata in the READY cycle. bus_rdata is 0 whenever bus_ready is low.
- R3: bus_ready is high for exactly one cycle per beat. While a strobe stays high after completion, no further READY is given. A new command is accepted only after bus_rd and bus_wr have both been low at a clock edge.
- R4: A cycle with bus_io high never reads or writes the memory, even when its address falls inside the memory range.
- R5: An unclaimed cycle gets no READY and changes no state. Unclaimed cycles are an unassigned port number, a memory address at or above MEM_DEPTH, a double-width access whose second word is out of range, or bus_rd and bus_wr both high. For such a cycle, bus_timeout pulses high for one cycle TIMEOUT_CYC cycles after the edge that first saw the strobe, if the strobe is still held.
- R6: A write to the control port (port 0x61) stores only bus_wdata[7:0], with bits above 7 cleared. A read of that port returns the stored value.
- R7: With bus_wide high on a memory cycle at address A, the block gives two READY pulses on consecutive cycles. A read returns word A and then word A+1. A write stores bus_wdata at the first edge to word A and at the next edge to word A+1. bus_wide has no effect on port cycles.
- R8: A read of the status port (port 0x64) returns 0x2 when the input buffer is full and 0 when it is empty. A read of the data port (port 0x60) returns the buffered byte zero-extended.
- R9: A read of the data port empties the buffer. A push_valid pulse loads push_byte and marks the buffer full. If a push and a data-port read meet on the same edge, the read returns the old byte and the buffer ends full with the new byte.
- R10: Writes to the status port and the data port complete with READY but change neither the flag nor the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Memory address or port number |
| bus_wdata | input | DATA_W | Write data from the master |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_io | input | 1 | High marks a port-space cycle |
| bus_wide | input | 1 | Double-width memory transfer (two beats) |
| bus_rdata | output | DATA_W | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | One-cycle completion pulse per beat |
| bus_timeout | output | 1 | One-cycle pulse for an unclaimed cycle |
| push_valid | input | 1 | Device side loads the input buffer |
| push_byte | input | 8 | Byte loaded into the input buffer |

## Verification
The assertions check several rules on every cycle. READY never runs longer than two beats, and a fresh READY always follows a cycle with a strobe high. READY and timeout never coincide, and a memory write is never issued during a port-space cycle. A push always leaves the buffer full, and a lone data-port read always leaves it empty. Only the bench scenarios can show the rest. These cover the data values that come back, including zero extension, word order in double-width beats and the old-byte return when a push and a read collide. They also cover the exact timeout delay, and the absence of any change after unclaimed cycles and read-only port writes, which the bench confirms by reading the state back.

// File: rtl/bus_responder_pkg.sv
package bus_responder_pkg;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_MEM,
        TGT_STAT,
        TGT_DATA,
        TGT_CTRL
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BEAT2,
        ST_HOLD,
        ST_STALL
    } st_e;

    localparam int unsigned STAT_FULL_BIT = 1;

endpackage

// File: rtl/bus_target_decode.sv
module bus_target_decode
    import bus_responder_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned MEM_DEPTH = 16,
    parameter int unsigned DATA_PORT = 'h60,
    parameter int unsigned CTRL_PORT = 'h61,
    parameter int unsigned STAT_PORT = 'h64
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              io,
    input  logic              wide,
    output tgt_e              tgt
);
    localparam int unsigned EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] last_word;

    always_comb begin
        last_word = {1'b0, addr} + EXT_W'(wide);
        tgt       = TGT_NONE;
        if (rd ^ wr) begin
            if (io) begin
                if (addr == ADDR_W'(DATA_PORT))      tgt = TGT_DATA;
                else if (addr == ADDR_W'(CTRL_PORT)) tgt = TGT_CTRL;
                else if (addr == ADDR_W'(STAT_PORT)) tgt = TGT_STAT;
            end else if (last_word < EXT_W'(MEM_DEPTH)) begin
                tgt = TGT_MEM;
            end
        end
    end

endmodule

// File: rtl/bus_mem_store.sv
module bus_mem_store #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[idx] = wdata;
        end
    end

    assign rdata = mem_q[idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

endmodule

// File: rtl/bus_port_regs.sv
module bus_port_regs
    import bus_responder_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              is_wr,
    input  tgt_e              tgt,
    input  logic [7:0]        wbyte,
    input  logic              push_valid,
    input  logic [7:0]        push_byte,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [7:0]        buf_byte;
        logic              full;
        logic [DATA_W-1:0] ctrl;
    } regs_t;

    regs_t r_q, r_d;
    logic  data_rd;

    assign data_rd = acc && !is_wr && (tgt == TGT_DATA);

    always_comb begin
        r_d = r_q;
        if (acc && is_wr && tgt == TGT_CTRL) begin
            r_d.ctrl = {{(DATA_W-8){1'b0}}, wbyte};
        end
        if (data_rd) begin
            r_d.full = 1'b0;
        end
        if (push_valid) begin
            r_d.buf_byte = push_byte;
            r_d.full     = 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (tgt)
            TGT_STAT: rdata[STAT_FULL_BIT] = r_q.full;
            TGT_DATA: rdata = {{(DATA_W-8){1'b0}}, r_q.buf_byte};
            TGT_CTRL: rdata = r_q.ctrl;
            default:  rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R9
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd && !push_valid |=> !r_q.full);

    // R9
    push_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |=> r_q.full);

endmodule

// File: rtl/bus_responder.sv
module bus_responder
    import bus_responder_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned MEM_DEPTH   = 16,
    parameter int unsigned TIMEOUT_CYC = 8,
    parameter int unsigned DATA_PORT   = 'h60,
    parameter int unsigned CTRL_PORT   = 'h61,
    parameter int unsigned STAT_PORT   = 'h64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_io,
    input  logic              bus_wide,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic              bus_timeout,
    input  logic              push_valid,
    input  logic [7:0]        push_byte
);
    localparam int unsigned IDX_W = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);

    typedef struct packed {
        st_e               st;
        logic [IDX_W-1:0]  idx;
        logic              is_wr;
        logic [CNT_W-1:0]  cnt;
        logic              ready;
        logic              timeout;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t              s_q, s_d;
    tgt_e              tgt;
    logic              cmd;
    logic              mem_we;
    logic [IDX_W-1:0]  mem_idx;
    logic [DATA_W-1:0] mem_rdata;
    logic              port_acc;
    logic [DATA_W-1:0] port_rdata;

    assign cmd = bus_rd || bus_wr;

    bus_target_decode #(
        .ADDR_W    (ADDR_W),
        .MEM_DEPTH (MEM_DEPTH),
        .DATA_PORT (DATA_PORT),
        .CTRL_PORT (CTRL_PORT),
        .STAT_PORT (STAT_PORT)
    ) decode_i (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .io   (bus_io),
        .wide (bus_wide && !bus_io),
        .tgt  (tgt)
    );

    assign mem_idx = (s_q.st == ST_BEAT2) ? IDX_W'(s_q.idx + 1'b1)
                                          : bus_addr[IDX_W-1:0];

    bus_mem_store #(
        .DATA_W (DATA_W),
        .DEPTH  (MEM_DEPTH)
    ) mem_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .idx   (mem_idx),
        .wdata (bus_wdata),
        .rdata (mem_rdata)
    );

    bus_port_regs #(
        .DATA_W (DATA_W)
    ) ports_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (port_acc),
        .is_wr      (bus_wr),
        .tgt        (tgt),
        .wbyte      (bus_wdata[7:0]),
        .push_valid (push_valid),
        .push_byte  (push_byte),
        .rdata      (port_rdata)
    );

    always_comb begin
        s_d         = s_q;
        s_d.ready   = 1'b0;
        s_d.timeout = 1'b0;
        s_d.rdata   = '0;
        mem_we      = 1'b0;
        port_acc    = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (cmd) begin
                    if (tgt == TGT_NONE) begin
                        s_d.st  = ST_STALL;
                        s_d.cnt = '0;
                    end else begin
                        s_d.ready = 1'b1;
                        s_d.is_wr = bus_wr;
                        s_d.idx   = bus_addr[IDX_W-1:0];
                        if (tgt == TGT_MEM) begin
                            if (bus_wr) mem_we    = 1'b1;
                            else        s_d.rdata = mem_rdata;
                            s_d.st = bus_wide ? ST_BEAT2 : ST_HOLD;
                        end else begin
                            port_acc = 1'b1;
                            if (!bus_wr) s_d.rdata = port_rdata;
                            s_d.st = ST_HOLD;
                        end
                    end
                end
            end
            ST_BEAT2: begin
                s_d.ready = 1'b1;
                if (s_q.is_wr) mem_we    = 1'b1;
                else           s_d.rdata = mem_rdata;
                s_d.st = ST_HOLD;
            end
            ST_HOLD: begin
                if (!cmd) s_d.st = ST_IDLE;
            end
            ST_STALL: begin
                if (!cmd) begin
                    s_d.st = ST_IDLE;
                end else if (s_q.cnt == CNT_W'(TIMEOUT_CYC - 1)) begin
                    s_d.timeout = 1'b1;
                    s_d.st      = ST_HOLD;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_ready   = s_q.ready;
    assign bus_timeout = s_q.timeout;
    assign bus_rdata   = s_q.rdata;

    // R3
    ready_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready && $past(bus_ready) |=> !bus_ready);

    // R3
    ready_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ready) |-> $past(bus_rd || bus_wr));

    // R5
    ready_vs_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_ready && bus_timeout));

    // R4
    io_never_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && (s_q.st == ST_IDLE) |-> !bus_io);

endmodule

// File: tb/bus_responder_tb_top.sv
module bus_responder_tb_top;

    localparam int TO = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_io = 1'b0, bus_wide = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_ready, bus_timeout;
    logic        push_valid = 1'b0;
    logic [7:0]  push_byte = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bus_responder #(.TIMEOUT_CYC(TO)) dut_i (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_rd (bus_rd), .bus_wr (bus_wr), .bus_io (bus_io), .bus_wide (bus_wide),
        .bus_rdata (bus_rdata), .bus_ready (bus_ready), .bus_timeout (bus_timeout),
        .push_valid (push_valid), .push_byte (push_byte)
    );

    typedef struct packed {
        logic        io;
        logic        rd;
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic        rdy;
        logic [31:0] rdata;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,1'b1,8'h00,32'h11112222,1'b1,32'h0,8'd2},        // R2
        '{1'b0,1'b1,1'b0,8'h00,32'h0,1'b1,32'h11112222,8'd2},        // R2
        '{1'b0,1'b0,1'b1,8'h0F,32'hDEADBEEF,1'b1,32'h0,8'd2},        // R2 top word
        '{1'b0,1'b1,1'b0,8'h0F,32'h0,1'b1,32'hDEADBEEF,8'd2},        // R2
        '{1'b0,1'b0,1'b1,8'h04,32'hAAAA0004,1'b1,32'h0,8'd2},        // R2
        '{1'b0,1'b0,1'b1,8'h05,32'hBBBB0005,1'b1,32'h0,8'd2},        // R2
        '{1'b0,1'b0,1'b1,8'h03,32'h30303030,1'b1,32'h0,8'd2},        // R2
        '{1'b1,1'b0,1'b1,8'h03,32'h00000055,1'b0,32'h0,8'd4},        // R4 io to mem-like address
        '{1'b1,1'b1,1'b0,8'h03,32'h0,1'b0,32'h0,8'd4},               // R4
        '{1'b0,1'b1,1'b0,8'h03,32'h0,1'b1,32'h30303030,8'd4},        // R4 memory untouched
        '{1'b1,1'b0,1'b1,8'h61,32'hFFFFFF7E,1'b1,32'h0,8'd6},        // R6
        '{1'b1,1'b1,1'b0,8'h61,32'h0,1'b1,32'h0000007E,8'd6},        // R6 zero extension
        '{1'b1,1'b0,1'b1,8'h64,32'h000000FF,1'b1,32'h0,8'd10},       // R10
        '{1'b1,1'b0,1'b1,8'h60,32'h00000099,1'b1,32'h0,8'd10},       // R10
        '{1'b1,1'b1,1'b0,8'h64,32'h0,1'b1,32'h0,8'd10},              // R10 flag still clear
        '{1'b0,1'b1,1'b0,8'h10,32'h0,1'b0,32'h0,8'd5},               // R5 above depth
        '{1'b0,1'b0,1'b1,8'h20,32'hEEEEEEEE,1'b0,32'h0,8'd5},        // R5 no alias write
        '{1'b0,1'b1,1'b1,8'h00,32'h99999999,1'b0,32'h0,8'd5},        // R5 both strobes
        '{1'b0,1'b1,1'b0,8'h00,32'h0,1'b1,32'h11112222,8'd5}         // R5 word 0 unchanged
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_op(input logic io, input logic rd, input logic wr,
                          input logic [7:0] a, input logic [31:0] d,
                          output logic rdy, output logic [31:0] q);
        bus_io = io; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        rdy = bus_ready; q = bus_rdata;
        bus_rd = 1'b0; bus_wr = 1'b0; bus_io = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        push_valid = 1'b1; push_byte = b;
        @(posedge clk); @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic        rdy, r2, r3;
        logic [31:0] q, q2;
        int          n, pulses;
        bit          saw_rdy;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", {31'b0, bus_ready}, 32'h0);
        check("R1 timeout", {31'b0, bus_timeout}, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        bus_op(1'b0, 1'b1, 1'b0, 8'h07, 32'h0, rdy, q);
        check("R1 mem word", q, 32'h0);
        bus_op(1'b1, 1'b1, 1'b0, 8'h61, 32'h0, rdy, q);
        check("R1 ctrl", q, 32'h0);

        for (int i = 0; i < NV; i++) begin
            bus_op(VEC[i].io, VEC[i].rd, VEC[i].wr, VEC[i].addr, VEC[i].wdata, rdy, q);
            check($sformatf("R%0d vec%0d ready", VEC[i].req, i), {31'b0, rdy}, {31'b0, VEC[i].rdy});
            check($sformatf("R%0d vec%0d rdata", VEC[i].req, i), q, VEC[i].rdata);
        end

        // R3 held strobe yields one READY only
        bus_io = 1'b0; bus_rd = 1'b1; bus_addr = 8'h00; pulses = 0;
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); @(negedge clk);
            if (bus_ready) pulses++;
        end
        check("R3 pulses while held", pulses, 1);
        bus_rd = 1'b0;
        @(posedge clk); @(negedge clk);
        bus_op(1'b0, 1'b1, 1'b0, 8'h00, 32'h0, rdy, q);
        check("R3 accepted after release", {31'b0, rdy}, 32'h1);

        // R7 wide read of words 4,5
        bus_wide = 1'b1; bus_rd = 1'b1; bus_addr = 8'h04;
        @(posedge clk); @(negedge clk); rdy = bus_ready; q = bus_rdata;
        @(posedge clk); @(negedge clk); r2 = bus_ready; q2 = bus_rdata;
        @(posedge clk); @(negedge clk); r3 = bus_ready;
        bus_rd = 1'b0; bus_wide = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R7 beat1 ready", {31'b0, rdy}, 32'h1);
        check("R7 beat1 low word", q, 32'hAAAA0004);
        check("R7 beat2 ready", {31'b0, r2}, 32'h1);
        check("R7 beat2 high word", q2, 32'hBBBB0005);
        check("R7 no third beat", {31'b0, r3}, 32'h0);

        // R7 wide write to words 6,7
        bus_wide = 1'b1; bus_wr = 1'b1; bus_addr = 8'h06; bus_wdata = 32'h0600CAFE;
        @(posedge clk); @(negedge clk); rdy = bus_ready; bus_wdata = 32'h0700BEEF;
        @(posedge clk); @(negedge clk); r2 = bus_ready;
        bus_wr = 1'b0; bus_wide = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R7 write beats", {30'b0, rdy, r2}, 32'h3);
        bus_op(1'b0, 1'b1, 1'b0, 8'h06, 32'h0, rdy, q);
        check("R7 word A", q, 32'h0600CAFE);
        bus_op(1'b0, 1'b1, 1'b0, 8'h07, 32'h0, rdy, q);
        check("R7 word A+1", q, 32'h0700BEEF);
        bus_wide = 1'b1;
        bus_op(1'b0, 1'b1, 1'b0, 8'h0F, 32'h0, rdy, q);
        bus_wide = 1'b0;
        check("R7 wide past end unclaimed", {31'b0, rdy}, 32'h0);

        // R8 and R9 input buffer
        push(8'hA5);
        bus_op(1'b1, 1'b1, 1'b0, 8'h64, 32'h0, rdy, q);
        check("R8 status full", q, 32'h2);
        bus_op(1'b1, 1'b1, 1'b0, 8'h60, 32'h0, rdy, q);
        check("R8 data byte", q, 32'h000000A5);
        bus_op(1'b1, 1'b1, 1'b0, 8'h64, 32'h0, rdy, q);
        check("R9 cleared by read", q, 32'h0);
        push(8'h3C);
        push_valid = 1'b1; push_byte = 8'h5A;
        bus_io = 1'b1; bus_rd = 1'b1; bus_addr = 8'h60;
        @(posedge clk); @(negedge clk);
        push_valid = 1'b0; q = bus_rdata;
        bus_io = 1'b0; bus_rd = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R9 collision returns old byte", q, 32'h0000003C);
        bus_op(1'b1, 1'b1, 1'b0, 8'h64, 32'h0, rdy, q);
        check("R9 push wins flag", q, 32'h2);
        bus_op(1'b1, 1'b0, 1'b1, 8'h60, 32'h00000011, rdy, q);
        bus_op(1'b1, 1'b1, 1'b0, 8'h60, 32'h0, rdy, q);
        check("R10 data port write ignored", q, 32'h0000005A);

        // R5 timeout on unassigned port
        bus_io = 1'b1; bus_rd = 1'b1; bus_addr = 8'h70; n = 0; saw_rdy = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(posedge clk); n++; @(negedge clk);
            if (bus_ready) saw_rdy = 1'b1;
            if (bus_timeout) break;
        end
        check("R5 timeout delay", n, TO + 1);
        check("R5 no ready", {31'b0, saw_rdy}, 32'h0);
        @(posedge clk); @(negedge clk);
        check("R5 timeout single pulse", {31'b0, bus_timeout}, 32'h0);
        bus_io = 1'b0; bus_rd = 1'b0;
        @(posedge clk); @(negedge clk);

        finish_run();
    end

endmodule